// File: doc/BRIEF.md
# Load-Use Hazard Stall Detector

This block sits beside the execute stage of an in-order pipeline. It compares the source registers of the instruction now in execute with the destination of the instruction one slot ahead, which sits in the execute/memory latch. If that older instruction is a load, its data only exists after the memory access, so forwarding cannot cover a consumer directly behind it. When such a dependency exists, the detector raises the stall bits that freeze fetch, decode and execute for the current cycle. The pipeline control outside this block inserts the bubble.

The load's destination is its rd field when it writes rd, and otherwise its rt field when it writes rt. A load that claims neither destination is malformed, and the block flags it on a separate error output. The block is purely combinational, and all of its pins are plain control signals. A build parameter selects between two variants. In one, detection is always on. In the other, detection runs only while the enable input is high.

Top module: `ldu_hazard_detect`

## Requirements
- R1: With `em_is_load` low, `stall_vec` and `load_tgt_err` are both zero, whatever the other inputs are.
- R2: When the load has `em_wr_rd` set, `em_rd` is its destination and `em_rt` is ignored, even if `em_wr_rt` is also set.
- R3: When the load has `em_wr_rd` clear and `em_wr_rt` set, `em_rt` is its destination.
- R4: `load_tgt_err` is 1 exactly when detection is active, the latch holds a load, and both `em_wr_rd` and `em_wr_rt` are clear.
- R5: A stall is raised when `ex_rd_rs` is set and `ex_rs` equals the load destination.
- R6: A stall is raised when `ex_rd_rt` is set and `ex_rt` equals the load destination. A register number that matches but is not read causes no stall.
- R7: The stall vector is 5 bits wide: bit 0 fetch, bit 1 decode, bit 2 execute, bit 3 memory, bit 4 writeback. A stall drives exactly 5'b00111. Otherwise the vector is 5'b00000.
- R8: With `ALWAYS_ON`=0 and `detect_en` low, both outputs are zero.
- R9: With `ALWAYS_ON`=1, `detect_en` has no effect on either output.
- R10: Register number 0 is compared like any other register number. It is given no special treatment.
- R11: A malformed load (R4) never produces a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| em_is_load | input | 1 | Instruction in the execute/memory latch is a load |
| em_wr_rd | input | 1 | That instruction writes its rd field |
| em_wr_rt | input | 1 | That instruction writes its rt field |
| em_rd | input | REG_W | rd register number of that instruction |
| em_rt | input | REG_W | rt register number of that instruction |
| ex_rd_rs | input | 1 | Execute-stage instruction reads rs |
| ex_rd_rt | input | 1 | Execute-stage instruction reads rt |
| ex_rs | input | REG_W | rs register number in execute |
| ex_rt | input | REG_W | rt register number in execute |
| detect_en | input | 1 | Detection enable; used only when ALWAYS_ON=0 |
| stall_vec | output | 5 | Per-stage stall bits, index 0 fetch to 4 writeback |
| load_tgt_err | output | 1 | Load with no destination field |

## Verification
Both outputs are combinational, so each result is due in the same cycle as the inputs that cause it, with no register in the path. The bench drives a new input vector just after a falling clock edge. It waits one nanosecond for the logic to settle and then compares the outputs, well before the next rising edge. Two instances, one for each variant, see the same vector. The sweep walks every flag combination against a register set that includes 0, neighbouring numbers and the top register.

// File: rtl/ldu_hazard_pkg.sv
package ldu_hazard_pkg;
  localparam int STAGE_CNT  = 5;
  localparam int IDX_FETCH  = 0;
  localparam int IDX_DECODE = 1;
  localparam int IDX_EXEC   = 2;
  localparam int IDX_MEM    = 3;
  localparam int IDX_WB     = 4;
  localparam int SRC_CNT    = 2;
  localparam int SRC_RS     = 0;
  localparam int SRC_RT     = 1;
endpackage

// File: rtl/ldu_dest_pick.sv
module ldu_dest_pick #(
  parameter int REG_W = 5
) (
  input  logic             wr_rd,
  input  logic             wr_rt,
  input  logic [REG_W-1:0] rd,
  input  logic [REG_W-1:0] rt,
  output logic [REG_W-1:0] dest,
  output logic             dest_ok
);
  // rd has priority over rt
  always_comb begin
    dest_ok = wr_rd | wr_rt;
    if (wr_rd) dest = rd;
    else       dest = rt;
  end
endmodule

// File: rtl/ldu_src_cmp.sv
module ldu_src_cmp #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [NSRC-1:0]            rd_en,
  input  logic [NSRC-1:0][REG_W-1:0] idx,
  input  logic [REG_W-1:0]           dest,
  output logic                       hit
);
  logic [NSRC-1:0] match;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign match[i] = rd_en[i] && (idx[i] == dest);
  end

  assign hit = |match;
endmodule

// File: rtl/ldu_stall_fan.sv
module ldu_stall_fan
  import ldu_hazard_pkg::*;
(
  input  logic                 hold,
  output logic [STAGE_CNT-1:0] vec
);
  for (genvar s = 0; s < STAGE_CNT; s++) begin : g_stage
    if (s <= IDX_EXEC) begin : g_front
      assign vec[s] = hold;
    end else begin : g_back
      assign vec[s] = 1'b0;
    end
  end
endmodule

// File: rtl/ldu_hazard_detect.sv
module ldu_hazard_detect
  import ldu_hazard_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter bit ALWAYS_ON = 1'b0
) (
  input  logic                 em_is_load,
  input  logic                 em_wr_rd,
  input  logic                 em_wr_rt,
  input  logic [REG_W-1:0]     em_rd,
  input  logic [REG_W-1:0]     em_rt,
  input  logic                 ex_rd_rs,
  input  logic                 ex_rd_rt,
  input  logic [REG_W-1:0]     ex_rs,
  input  logic [REG_W-1:0]     ex_rt,
  input  logic                 detect_en,
  output logic [STAGE_CNT-1:0] stall_vec,
  output logic                 load_tgt_err
);
  logic                            active;
  logic [REG_W-1:0]                ld_dest;
  logic                            ld_dest_ok;
  logic                            src_hit;
  logic [SRC_CNT-1:0]              src_en;
  logic [SRC_CNT-1:0][REG_W-1:0]   src_idx;

  if (ALWAYS_ON) begin : g_fixed
    logic unused_en;
    assign unused_en = detect_en;
    assign active    = em_is_load;
  end else begin : g_gated
    assign active = em_is_load & detect_en;
  end

  ldu_dest_pick #(.REG_W(REG_W)) u_dest (
    .wr_rd   (em_wr_rd),
    .wr_rt   (em_wr_rt),
    .rd      (em_rd),
    .rt      (em_rt),
    .dest    (ld_dest),
    .dest_ok (ld_dest_ok)
  );

  always_comb begin
    src_en[SRC_RS]  = ex_rd_rs;
    src_en[SRC_RT]  = ex_rd_rt;
    src_idx[SRC_RS] = ex_rs;
    src_idx[SRC_RT] = ex_rt;
  end

  ldu_src_cmp #(.REG_W(REG_W), .NSRC(SRC_CNT)) u_cmp (
    .rd_en (src_en),
    .idx   (src_idx),
    .dest  (ld_dest),
    .hit   (src_hit)
  );

  ldu_stall_fan u_fan (
    .hold (active & ld_dest_ok & src_hit),
    .vec  (stall_vec)
  );

  assign load_tgt_err = active & ~ld_dest_ok;
endmodule

// File: rtl/ldu_hazard_detect_chk.sv
module ldu_hazard_detect_chk
  import ldu_hazard_pkg::*;
#(
  parameter bit ALWAYS_ON = 1'b0
) (
  input logic                 em_is_load,
  input logic                 em_wr_rd,
  input logic                 em_wr_rt,
  input logic                 ex_rd_rs,
  input logic                 ex_rd_rt,
  input logic                 detect_en,
  input logic [STAGE_CNT-1:0] stall_vec,
  input logic                 load_tgt_err
);
  always_comb begin
    assert_back_clear_R7: assert (!stall_vec[IDX_MEM] && !stall_vec[IDX_WB])
      else $error("memory/writeback stall bit set");
    assert_front_same_R7: assert (stall_vec[IDX_FETCH] == stall_vec[IDX_DECODE]
                                  && stall_vec[IDX_DECODE] == stall_vec[IDX_EXEC])
      else $error("front stall bits disagree");
    if (!em_is_load) begin
      assert_quiet_no_load_R1: assert (stall_vec == '0 && !load_tgt_err)
        else $error("output without a load");
    end
    if (load_tgt_err) begin
      assert_err_cause_R4: assert (em_is_load && !em_wr_rd && !em_wr_rt)
        else $error("error without malformed load");
      assert_err_no_stall_R11: assert (stall_vec == '0)
        else $error("stall with malformed load");
    end
    if (!ALWAYS_ON && !detect_en) begin
      assert_quiet_disabled_R8: assert (stall_vec == '0 && !load_tgt_err)
        else $error("output while disabled");
    end
    if (stall_vec[IDX_FETCH]) begin
      assert_stall_needs_read_R5: assert (ex_rd_rs || ex_rd_rt)
        else $error("stall without a source read");
    end
  end
endmodule

bind ldu_hazard_detect ldu_hazard_detect_chk #(.ALWAYS_ON(ALWAYS_ON)) u_chk (
  .em_is_load   (em_is_load),
  .em_wr_rd     (em_wr_rd),
  .em_wr_rt     (em_wr_rt),
  .ex_rd_rs     (ex_rd_rs),
  .ex_rd_rt     (ex_rd_rt),
  .detect_en    (detect_en),
  .stall_vec    (stall_vec),
  .load_tgt_err (load_tgt_err)
);

// File: tb/ldu_hazard_detect_tb.sv
module ldu_hazard_detect_tb;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             em_is_load, em_wr_rd, em_wr_rt, ex_rd_rs, ex_rd_rt, detect_en;
  logic [REG_W-1:0] em_rd, em_rt, ex_rs, ex_rt;
  logic [4:0]       stall_a, stall_b;
  logic             err_a, err_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  ldu_hazard_detect #(.REG_W(REG_W), .ALWAYS_ON(1'b0)) u_dut (
    .em_is_load(em_is_load), .em_wr_rd(em_wr_rd), .em_wr_rt(em_wr_rt),
    .em_rd(em_rd), .em_rt(em_rt), .ex_rd_rs(ex_rd_rs), .ex_rd_rt(ex_rd_rt),
    .ex_rs(ex_rs), .ex_rt(ex_rt), .detect_en(detect_en),
    .stall_vec(stall_a), .load_tgt_err(err_a)
  );

  ldu_hazard_detect #(.REG_W(REG_W), .ALWAYS_ON(1'b1)) u_dut_fix (
    .em_is_load(em_is_load), .em_wr_rd(em_wr_rd), .em_wr_rt(em_wr_rt),
    .em_rd(em_rd), .em_rt(em_rt), .ex_rd_rs(ex_rd_rs), .ex_rd_rt(ex_rd_rt),
    .ex_rs(ex_rs), .ex_rt(ex_rt), .detect_en(detect_en),
    .stall_vec(stall_b), .load_tgt_err(err_b)
  );

  function automatic logic [REG_W-1:0] pick_reg(input int k);
    case (k)
      0:       return 5'd0;
      1:       return 5'd1;
      2:       return 5'd2;
      default: return 5'd31;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h (load=%0b wrd=%0b wrt=%0b rd=%0d rt=%0d rs_rd=%0b rt_rd=%0b rs=%0d ert=%0d en=%0b)",
               tag, act, exp, em_is_load, em_wr_rd, em_wr_rt, em_rd, em_rt,
               ex_rd_rs, ex_rd_rt, ex_rs, ex_rt, detect_en);
    end
  endtask

  // Expected results, computed from the requirements.
  task automatic expect_out(input bit fixed, output int exp_stall, output int exp_err,
                            output string tag);
    bit act_on, ok, hit_rs, hit_rt;
    logic [REG_W-1:0] tgt;
    act_on = em_is_load && (fixed || detect_en);
    ok     = em_wr_rd || em_wr_rt;
    tgt    = em_wr_rd ? em_rd : em_rt;
    hit_rs = ex_rd_rs && (ex_rs == tgt);
    hit_rt = ex_rd_rt && (ex_rt == tgt);
    exp_err   = (act_on && !ok) ? 1 : 0;
    exp_stall = (act_on && ok && (hit_rs || hit_rt)) ? 5'b00111 : 5'b00000;
    if (!em_is_load)                   tag = "R1";
    else if (!fixed && !detect_en)     tag = "R8";
    else if (fixed && !detect_en)      tag = "R9";
    else if (!ok)                      tag = "R11";
    else if (tgt == '0 && (hit_rs || hit_rt)) tag = "R10";
    else if (hit_rs)                   tag = em_wr_rd ? "R2/R5" : "R3/R5";
    else if (hit_rt)                   tag = em_wr_rd ? "R2/R6" : "R3/R6";
    else                               tag = "R6";
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int es, ee;
    string tg;
    {em_is_load, em_wr_rd, em_wr_rt, ex_rd_rs, ex_rd_rt, detect_en} = '0;
    {em_rd, em_rt, ex_rs, ex_rt} = '0;
    @(negedge clk); #1;
    check("R1 idle", int'(stall_a), 0);
    check("R1 idle err", int'(err_a), 0);

    for (int v = 0; v < (1 << 14); v++) begin
      @(negedge clk);
      {em_is_load, em_wr_rd, em_wr_rt, ex_rd_rs, ex_rd_rt, detect_en} = 6'(v >> 8);
      em_rd = pick_reg((v >> 6) & 3);
      em_rt = pick_reg((v >> 4) & 3);
      ex_rs = pick_reg((v >> 2) & 3);
      ex_rt = pick_reg(v & 3);
      #1;
      expect_out(1'b0, es, ee, tg);
      check({tg, " stall gated"}, int'(stall_a), es);
      check(ee != 0 ? "R4 err gated" : "R4 noerr gated", int'(err_a), ee);
      expect_out(1'b1, es, ee, tg);
      check({tg, " stall fixed"}, int'(stall_b), es);
      check(ee != 0 ? "R4 err fixed" : "R4 noerr fixed", int'(err_b), ee);
      check("R7 back bits", int'(stall_b[4:3]), 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule